// File: doc/BRIEF.md
# Interrupt Event Collector with Masked Status

This block gathers single-cycle event pulses from the command engine, data path, FIFO and card-detect logic of a storage-card host into a sticky raw status word. Software clears a bit by writing a one to that bit of the raw status register. A separate mask register selects which captured events may raise the interrupt. The masked view, raw AND mask, is readable on its own.

A single level-sensitive interrupt line is driven high while any masked bit is set and the enable bit of the control register is on. Two summary outputs, taken from the raw word and not the masked word, tell the surrounding logic whether any error-class or any completion-class event is pending. Register access uses a word-addressed write strobe, a 32-bit write data bus and a combinational read data bus.

Register layout (byte offsets, low two address bits zero): 0x0 control, 0x4 mask, 0x8 masked status (read-only), 0xC raw status (write one to clear).

Top module: `irq_stat_unit`

## Requirements
- R1: After reset the raw status, the mask and the control register all read zero, and `irq_o`, `err_sum_o` and `done_sum_o` are low.
- R2: An event pulse on an implemented bit sets that raw status bit at the next clock edge, and the bit stays set until cleared. The implemented bits are 1 to 16, 30 and 31 (mask 0xC001FFFE).
- R3: A write to offset 0xC clears every raw bit whose write data bit is 1 and leaves the bits written with 0 unchanged.
- R4: When an event pulse and a clearing write hit the same raw bit in the same cycle, the bit ends up set.
- R5: Bit positions 0 and 17 to 29 ignore event pulses; they read zero in the raw status, and writes leave them zero in the mask.
- R6: Offset 0x8 reads the raw status ANDed with the mask register; offset 0x4 reads back the mask written there, restricted to implemented bits.
- R7: `irq_o` is high exactly when bit 4 of the control register (offset 0x0) is set and at least one masked status bit is set; other control bits read zero.
- R8: `err_sum_o` is the OR of raw bits 1, 6, 7, 8, 9, 11, 12, 13 and 15, independent of the mask and the enable.
- R9: `done_sum_o` is the OR of raw bits 2, 3, 10 and 14, independent of the mask and the enable.
- R10: A write to the read-only offset 0x8, or any access whose two low address bits are not zero, changes no register and such a read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event pulses, one per status bit position |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Level interrupt request |
| err_sum_o | output | 1 | Any error-class raw bit set |
| done_sum_o | output | 1 | Any completion-class raw bit set |

## Verification
The properties assume events arrive as synchronous one-cycle levels sampled at the clock edge, and that a clearing write is a single-cycle strobe; a rising error or done summary is therefore blamed on an event in the previous cycle, which holds only if nothing but events can set raw bits. The stimulus drives every input on the falling edge and holds it for one full cycle, so events, writes and their collisions are all synchronous. Random phases use sparse events (several random words ANDed) so that bits are frequently both set and cleared, and the address stream includes unaligned offsets.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

   localparam int unsigned STAT_W = 32;

   // positions that hold a sticky status flop
   localparam logic [STAT_W-1:0] IMPL_BITS  = 32'hC001_FFFE;
   // error class: 1,6,7,8,9,11,12,13,15
   localparam logic [STAT_W-1:0] ERR_BITS   = 32'h0000_BBC2;
   // completion class: 2,3,10,14
   localparam logic [STAT_W-1:0] DONE_BITS  = 32'h0000_440C;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_MASK  = 2'd1,
      SEL_MSTAT = 2'd2,
      SEL_RAW   = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/irq_raw_stat.sv
module irq_raw_stat #(
   parameter int unsigned         W    = 32,
   parameter logic [W-1:0]        IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic [W-1:0] clr_bits_i,
   output logic [W-1:0] stat_o
);

   logic [W-1:0] stat_q;

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stat_q[i] <= 1'b0;
         else if (IMPL[i])
            // event takes priority over the clear
            stat_q[i] <= evt_i[i] | (stat_q[i] & ~clr_bits_i[i]);
         else
            stat_q[i] <= 1'b0;
      end
   end

   assign stat_o = stat_q;

   // R2 R4
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i & IMPL) != '0 |=> (stat_o & $past(evt_i & IMPL)) == $past(evt_i & IMPL));

   // R3
   clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_bits_i != '0 |=> (stat_o & $past(clr_bits_i & ~evt_i)) == '0);

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
   parameter int unsigned  W    = 32,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ctrl_we_i,
   input  logic         en_d_i,
   input  logic         mask_we_i,
   input  logic [W-1:0] mask_d_i,
   output logic         en_o,
   output logic [W-1:0] mask_o
);

   logic         en_q;
   logic [W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mask_q <= '0;
      end else begin
         if (ctrl_we_i) en_q   <= en_d_i;
         if (mask_we_i) mask_q <= mask_d_i & IMPL;
      end
   end

   assign en_o   = en_q;
   assign mask_o = mask_q;

   // R6
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we_i |=> $stable(mask_o));

endmodule

// File: rtl/irq_out_logic.sv
module irq_out_logic #(
   parameter int unsigned  W    = 32,
   parameter logic [W-1:0] ERR  = '0,
   parameter logic [W-1:0] DONE = '0
) (
   input  logic [W-1:0] raw_i,
   input  logic [W-1:0] mask_i,
   input  logic         en_i,
   output logic [W-1:0] masked_o,
   output logic         irq_o,
   output logic         err_o,
   output logic         done_o
);

   assign masked_o = raw_i & mask_i;
   assign irq_o    = en_i & (|masked_o);
   assign err_o    = |(raw_i & ERR);
   assign done_o   = |(raw_i & DONE);

endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
   import irq_stat_pkg::*;
#(
   parameter int unsigned       DATA_W    = STAT_W,
   parameter int unsigned       ADDR_W    = 4,
   parameter int unsigned       EN_BIT    = 4,
   parameter logic [DATA_W-1:0] IMPL_MAP  = IMPL_BITS,
   parameter logic [DATA_W-1:0] ERR_MAP   = ERR_BITS,
   parameter logic [DATA_W-1:0] DONE_MAP  = DONE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o,
   output logic              err_sum_o,
   output logic              done_sum_o
);

   localparam int unsigned SEL_LSB = 2;
   localparam int unsigned TOP_LSB = SEL_LSB + 2;

   if (DATA_W != STAT_W) begin : g_bad_width
      $error("irq_stat_unit: DATA_W must equal the status word width");
   end
   if (ADDR_W < TOP_LSB) begin : g_bad_addr
      $error("irq_stat_unit: ADDR_W too small for four registers");
   end
   if (EN_BIT >= DATA_W) begin : g_bad_en
      $error("irq_stat_unit: EN_BIT outside the data word");
   end
   if (((ERR_MAP | DONE_MAP) & ~IMPL_MAP) != '0) begin : g_bad_map
      $error("irq_stat_unit: summary groups use unimplemented bits");
   end

   logic              hit;
   reg_sel_e          sel;
   logic [DATA_W-1:0] raw_q, mask_q, masked;
   logic              en_q;
   logic [DATA_W-1:0] clr_bits;

   assign hit = (addr_i[SEL_LSB-1:0] == '0) && ((addr_i >> TOP_LSB) == '0);
   assign sel = reg_sel_e'(addr_i[SEL_LSB +: 2]);

   assign clr_bits = (wr_en_i && hit && sel == SEL_RAW) ? wdata_i : '0;

   irq_raw_stat #(.W(DATA_W), .IMPL(IMPL_MAP)) u_raw (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i),
      .clr_bits_i (clr_bits),
      .stat_o     (raw_q)
   );

   irq_cfg_regs #(.W(DATA_W), .IMPL(IMPL_MAP)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we_i (wr_en_i && hit && sel == SEL_CTRL),
      .en_d_i    (wdata_i[EN_BIT]),
      .mask_we_i (wr_en_i && hit && sel == SEL_MASK),
      .mask_d_i  (wdata_i),
      .en_o      (en_q),
      .mask_o    (mask_q)
   );

   irq_out_logic #(.W(DATA_W), .ERR(ERR_MAP), .DONE(DONE_MAP)) u_out (
      .raw_i    (raw_q),
      .mask_i   (mask_q),
      .en_i     (en_q),
      .masked_o (masked),
      .irq_o    (irq_o),
      .err_o    (err_sum_o),
      .done_o   (done_sum_o)
   );

   always_comb begin
      rdata_o = '0;
      if (hit) begin
         unique case (sel)
            SEL_CTRL:  rdata_o[EN_BIT] = en_q;
            SEL_MASK:  rdata_o = mask_q;
            SEL_MSTAT: rdata_o = masked;
            SEL_RAW:   rdata_o = raw_q;
            default:   rdata_o = '0;
         endcase
      end
   end

   // R7
   irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> en_q);

   // R8
   err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_sum_o) |-> ($past(evt_i) & ERR_MAP) != '0);

   // R9
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_sum_o) |-> ($past(evt_i) & DONE_MAP) != '0);

endmodule

// File: tb/irq_stat_unit_tb.sv
`timescale 1ns/1ps
module irq_stat_unit_tb;

   localparam logic [31:0] IMPL = 32'hC001_FFFE;
   localparam logic [31:0] ERRM = 32'h0000_BBC2;
   localparam logic [31:0] DONM = 32'h0000_440C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt = '0;
   logic        we = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, err_sum, done_sum;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_raw = '0, m_mask = '0;
   logic        m_en = 1'b0;
   logic [31:0] last_rd;
   logic        last_irq;

   always #2 clk = ~clk;

   irq_stat_unit u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .wr_en_i    (we),
      .addr_i     (addr),
      .wdata_i    (wdata),
      .rdata_o    (rdata),
      .irq_o      (irq),
      .err_sum_o  (err_sum),
      .done_sum_o (done_sum)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input logic [3:0] a);
      if (a[1:0] != 2'b00) return '0;
      case (a[3:2])
         2'd0:    return {27'd0, m_en, 4'd0};
         2'd1:    return m_mask;
         2'd2:    return m_raw & m_mask;
         default: return m_raw;
      endcase
   endfunction

   // entered at a falling edge; leaves at the next falling edge
   task automatic step(input logic [31:0] e, input logic w, input logic [3:0] a,
                       input logic [31:0] d);
      string rtag;
      logic  ok;
      evt = e; we = w; addr = a; wdata = d;
      #1;
      rtag = (a[1:0] != 0) ? "R10" : (a[3:2] == 2'd2) ? "R6" :
             (a[3:2] == 2'd3) ? "R2" : (a[3:2] == 2'd1) ? "R6" : "R7";
      chk(rtag, rdata, m_read(a));
      chk("R7", {31'd0, irq}, {31'd0, m_en && ((m_raw & m_mask) != 0)});
      chk("R8", {31'd0, err_sum}, {31'd0, (m_raw & ERRM) != 0});
      chk("R9", {31'd0, done_sum}, {31'd0, (m_raw & DONM) != 0});
      last_rd = rdata; last_irq = irq;
      ok = w && (a[1:0] == 2'b00);
      m_raw = (m_raw & ~((ok && a[3:2] == 2'd3) ? d : 32'd0)) | (e & IMPL);
      if (ok && a[3:2] == 2'd1) m_mask = d & IMPL;
      if (ok && a[3:2] == 2'd0) m_en = d[4];
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #700us;
      errors++;
      $display("FAIL watchdog: run did not complete (R1..)");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      evt = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      // R1: events during reset are not captured
      chk("R1", {29'd0, irq, err_sum, done_sum}, 32'd0);
      rst_n = 1'b1;
      evt = '0;
      @(negedge clk);
      step(0, 0, 4'hC, 0); chk("R1", last_rd, 32'd0);
      step(0, 0, 4'h4, 0); chk("R1", last_rd, 32'd0);
      step(0, 0, 4'h0, 0); chk("R1", last_rd, 32'd0);

      // R2 set and hold, R8/R9 summaries
      step(32'h0000_0084, 0, 4'hC, 0);
      step(0, 0, 4'hC, 0); chk("R2", last_rd, 32'h84);
      chk("R8", {31'd0, err_sum}, 32'd1);
      chk("R9", {31'd0, done_sum}, 32'd1);
      step(0, 0, 4'hC, 0); chk("R2", last_rd, 32'h84);

      // R3 clear only the bits written with one
      step(0, 1, 4'hC, 32'h0000_0080);
      step(0, 0, 4'hC, 0); chk("R3", last_rd, 32'h4);
      chk("R8", {31'd0, err_sum}, 32'd0);

      // R4 collision keeps the bit
      step(32'h4, 1, 4'hC, 32'h4);
      step(0, 0, 4'hC, 0); chk("R4", last_rd, 32'h4);

      // R5 reserved positions
      step(32'hFFFF_FFFF, 1, 4'h4, 32'hFFFF_FFFF);
      step(0, 0, 4'hC, 0); chk("R5", last_rd, 32'hC001_FFFE);
      step(0, 0, 4'h4, 0); chk("R5", last_rd, 32'hC001_FFFE);
      step(0, 1, 4'hC, 32'hFFFF_FFFF);
      step(0, 0, 4'hC, 0); chk("R3", last_rd, 32'd0);

      // R6/R7 masking and enable
      step(0, 1, 4'h4, 32'h0000_0008);
      step(32'h0000_000C, 1, 4'h0, 32'h0000_0010);
      step(0, 0, 4'h8, 0); chk("R6", last_rd, 32'h8);
      chk("R7", {31'd0, last_irq}, 32'd1);
      step(0, 1, 4'h0, 32'hFFFF_FFEF);
      step(0, 0, 4'h0, 0); chk("R7", last_rd, 32'd0);
      chk("R7", {31'd0, last_irq}, 32'd0);

      // R10 read-only and unaligned accesses
      step(0, 1, 4'h8, 32'hFFFF_FFFF);
      step(0, 1, 4'hD, 32'hFFFF_FFFF);
      step(0, 1, 4'h5, 32'h0);
      step(0, 0, 4'hC, 0); chk("R10", last_rd, 32'hC);
      step(0, 0, 4'h4, 0); chk("R10", last_rd, 32'h8);
      step(0, 0, 4'hF, 0); chk("R10", last_rd, 32'd0);

      // mixed traffic against the model
      for (int i = 0; i < 2000; i++) begin
         logic [31:0] e, d;
         e = $urandom & $urandom & $urandom;
         d = (i % 7 == 0) ? $urandom : ($urandom & $urandom);
         step(e, ($urandom % 3) == 0, 4'($urandom), d);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule